// File: doc/BRIEF.md
# Timecode Transmit Frame Timing Controller

This block produces the bit and frame timing for a longitudinal timecode transmitter. A divider reduces a selected source clock to a half-bit tick. Two half-bit ticks make one bit period, and 80 bit periods make one frame. The controller tells a downstream serializer and line encoder which bit is being sent (`bit_idx_o`), marks the first cycle of each frame, and flags whether a frame is in progress.

The source clock is one of two. The first is the system clock itself, where every cycle is a source pulse. The second is a recovered receive clock, where both of its edges count as source pulses, so its rate is doubled. The 12-bit divider value is loaded in two byte writes. A new value is applied only when the divider reloads, so a half-bit is never cut short.

Transmission starts only on a selected sync event, so the enable only ever produces whole frames. There are four possible sync events: a video line-5 strobe, a rising edge on a click input, a receive-sync-detect pulse and a software strobe. In free-run mode the end of each frame starts the next one. The first frame still waits for a sync event.

Top module: `ltc_tx_timing`

## Requirements
- R1: A write with `div_lo_we_i` loads divider bits 7:0 from `div_wdata_i[7:0]`. A write with `div_hi_we_i` loads divider bits 11:8 from `div_wdata_i[3:0]`. Bits 7:4 of a high-byte write are ignored.
- R2: `half_tick_o` pulses once every (divider + 1) source pulses. With `src_rx_i` = 0 every system cycle is a source pulse, so a divider of 0 gives a tick every cycle and a divider of 3 gives one every 4 cycles.
- R3: With `src_rx_i` = 1, each rising and each falling edge of `rx_clk_i` is one source pulse. A divider of 1 therefore gives one half-bit tick per receive clock period.
- R4: A divider write takes effect only at the next reload, which is a half-bit tick or a frame start. The half-bit already running keeps its old length.
- R5: During a frame, `bit_idx_o` counts from 0 to 79 and advances on every second half-bit tick. A frame lasts 160 × (divider + 1) source pulses.
- R6: `sync_sel_i` picks the sync event: 0 = `line5_i`, 1 = rising edge of `click_i`, 2 = `rx_sync_i`, 3 = `sw_sync_i`. Events on the inputs that are not selected have no effect.
- R7: When idle, a frame starts on the cycle after a selected sync event that arrives while `tx_en_i` = 1. In that cycle `frame_start_o` is high for one cycle, `frame_active_o` rises, `bit_idx_o` = 0, and the divider restarts from zero.
- R8: With `free_run_i` = 1 and `tx_en_i` = 1, the cycle after the final half-bit of bit 79 starts the next frame with no sync event. The first frame after idle still needs a sync event.
- R9: With `free_run_i` = 0, `frame_active_o` falls after bit 79 and the block waits for a new sync event.
- R10: Clearing `tx_en_i` in mid-frame does not stop the frame. It runs through bit 79 before `frame_active_o` falls.
- R11: Sync events that arrive while a frame is active neither restart nor shift the frame.
- R12: A `click_i` that stays high gives one sync event only. A new event needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_lo_we_i | input | 1 | Load divider low byte |
| div_hi_we_i | input | 1 | Load divider high nibble |
| div_wdata_i | input | 8 | Divider write data |
| src_rx_i | input | 1 | Source select: 0 system clock, 1 receive clock |
| rx_clk_i | input | 1 | Recovered receive clock level, synchronous to clk_i |
| sync_sel_i | input | 2 | Sync event select |
| free_run_i | input | 1 | Frame end starts the next frame |
| tx_en_i | input | 1 | Transmit enable |
| line5_i | input | 1 | Video line-5 strobe |
| click_i | input | 1 | External click level |
| rx_sync_i | input | 1 | Receive sync detect pulse |
| sw_sync_i | input | 1 | Software sync strobe |
| half_tick_o | output | 1 | Half-bit tick |
| bit_idx_o | output | 7 | Bit index in frame |
| frame_start_o | output | 1 | First cycle of a frame |
| frame_active_o | output | 1 | Frame in progress |

## Verification
A wrong divider count or a mistimed divider reload shows as the wrong `half_tick_o` spacing within one half-bit period. A divider restart missed at frame start shows up by the first tick of the frame. A fault in the half-bit or bit counter moves the fall of `frame_active_o`, or the next free-run `frame_start_o`, away from exactly 160 × (divider + 1) cycles after the start, so it appears by the end of the frame. A fault in sync selection, edge detection or idle gating gives a missing or extra `frame_start_o` one cycle after the event.

// File: rtl/ltc_tx_pkg.sv
package ltc_tx_pkg;
  typedef enum logic [1:0] {
    SYNC_LINE5 = 2'b00,
    SYNC_CLICK = 2'b01,
    SYNC_RXDET = 2'b10,
    SYNC_SOFT  = 2'b11
  } sync_sel_e;
endpackage

// File: rtl/ltc_src_gen.sv
module ltc_src_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic use_rx_i,
  input  logic rx_clk_i,
  output logic src_pulse_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_clk_i;
  end

  // both edges count: receive rate doubled
  assign src_pulse_o = use_rx_i ? (rx_clk_i ^ rx_q) : 1'b1;

  p_src_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_rx_i && $stable(rx_clk_i) |-> !src_pulse_o)
    else $error("p_src_edge_r3");
endmodule

// File: rtl/ltc_div.sv
module ltc_div #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             src_pulse_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int unsigned HI_W = DIV_W - 8;

  logic [DIV_W-1:0] div_reg_q, div_act_q, cnt_q;

  generate
    if (HI_W < 8) begin : g_hi_unused
      logic unused_hi;
      assign unused_hi = ^wdata_i[7:HI_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_reg_q <= '0;
    end else begin
      if (lo_we_i) div_reg_q[7:0]       <= wdata_i;
      if (hi_we_i) div_reg_q[DIV_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  assign tick_o = src_pulse_i && (cnt_q == div_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_act_q <= '0;
    end else if (restart_i || tick_o) begin
      cnt_q     <= '0;
      div_act_q <= div_reg_q;
    end else if (src_pulse_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_reload_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o && !restart_i |=> $stable(div_act_q))
    else $error("p_reload_only_r4");

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_act_q)
    else $error("p_cnt_bound_r2");

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0)
    else $error("p_wrap_r2");
endmodule

// File: rtl/ltc_sync_sel.sv
module ltc_sync_sel
  import ltc_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sync_sel_e sel_i,
  input  logic      line5_i,
  input  logic      click_i,
  input  logic      rx_sync_i,
  input  logic      sw_sync_i,
  output logic      evt_o
);
  logic click_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) click_q <= 1'b0;
    else         click_q <= click_i;
  end

  always_comb begin
    unique case (sel_i)
      SYNC_LINE5: evt_o = line5_i;
      SYNC_CLICK: evt_o = click_i && !click_q;
      SYNC_RXDET: evt_o = rx_sync_i;
      SYNC_SOFT:  evt_o = sw_sync_i;
      default:    evt_o = 1'b0;
    endcase
  end

  p_click_once_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && sel_i == SYNC_CLICK |=> !(evt_o && sel_i == SYNC_CLICK))
    else $error("p_click_once_r12");
endmodule

// File: rtl/ltc_frame_seq.sv
module ltc_frame_seq #(
  parameter int unsigned BITS_PER_FRAME = 80,
  parameter int unsigned IDX_W = $clog2(BITS_PER_FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic             en_i,
  input  logic             free_run_i,
  output logic             restart_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             frame_start_o,
  output logic             active_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS_PER_FRAME - 1);

  logic             active_q, half_q, start_q;
  logic [IDX_W-1:0] idx_q;
  logic             frame_end, chain;

  assign restart_o = !active_q && en_i && sync_i;
  assign frame_end = active_q && tick_i && half_q && (idx_q == LAST_IDX);
  assign chain     = free_run_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      start_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      start_q <= 1'b0;
      if (!active_q) begin
        half_q <= 1'b0;
        idx_q  <= '0;
        if (restart_o) begin
          active_q <= 1'b1;
          start_q  <= 1'b1;
        end
      end else if (tick_i) begin
        half_q <= !half_q;
        if (half_q) begin
          if (idx_q == LAST_IDX) begin
            idx_q    <= '0;
            active_q <= chain;
            start_q  <= chain;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign bit_idx_o     = idx_q;
  assign frame_start_o = start_q;
  assign active_o      = active_q;

  p_start_state_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> active_q && idx_q == '0 && !half_q)
    else $error("p_start_state_r7");

  p_rise_on_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(en_i && sync_i))
    else $error("p_rise_on_sync_r7");

  p_idx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX)
    else $error("p_idx_bound_r5");

  p_hold_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !frame_end |=> active_q && !start_q)
    else $error("p_hold_frame_r10");

  p_chain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && chain |=> start_q && active_q)
    else $error("p_chain_r8");

  p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !chain |=> !active_q)
    else $error("p_stop_r9");
endmodule

// File: rtl/ltc_tx_timing.sv
module ltc_tx_timing
  import ltc_tx_pkg::*;
#(
  parameter int unsigned DIV_W          = 12,
  parameter int unsigned BITS_PER_FRAME = 80,
  parameter int unsigned IDX_W          = $clog2(BITS_PER_FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_lo_we_i,
  input  logic             div_hi_we_i,
  input  logic [7:0]       div_wdata_i,
  input  logic             src_rx_i,
  input  logic             rx_clk_i,
  input  logic [1:0]       sync_sel_i,
  input  logic             free_run_i,
  input  logic             tx_en_i,
  input  logic             line5_i,
  input  logic             click_i,
  input  logic             rx_sync_i,
  input  logic             sw_sync_i,
  output logic             half_tick_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             frame_start_o,
  output logic             frame_active_o
);
  logic src_pulse, tick, sync_evt, restart;

  ltc_src_gen u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .use_rx_i    (src_rx_i),
    .rx_clk_i    (rx_clk_i),
    .src_pulse_o (src_pulse)
  );

  ltc_div #(.DIV_W(DIV_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_we_i     (div_lo_we_i),
    .hi_we_i     (div_hi_we_i),
    .wdata_i     (div_wdata_i),
    .src_pulse_i (src_pulse),
    .restart_i   (restart),
    .tick_o      (tick)
  );

  ltc_sync_sel u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sync_sel_e'(sync_sel_i)),
    .line5_i   (line5_i),
    .click_i   (click_i),
    .rx_sync_i (rx_sync_i),
    .sw_sync_i (sw_sync_i),
    .evt_o     (sync_evt)
  );

  ltc_frame_seq #(.BITS_PER_FRAME(BITS_PER_FRAME), .IDX_W(IDX_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .sync_i        (sync_evt),
    .en_i          (tx_en_i),
    .free_run_i    (free_run_i),
    .restart_o     (restart),
    .bit_idx_o     (bit_idx_o),
    .frame_start_o (frame_start_o),
    .active_o      (frame_active_o)
  );

  assign half_tick_o = tick;
endmodule

// File: tb/ltc_tx_timing_bench.sv
module ltc_tx_timing_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       div_lo_we = 1'b0, div_hi_we = 1'b0;
  logic [7:0] div_wdata = '0;
  logic       src_rx = 1'b0, rx_clk = 1'b0;
  logic [1:0] sync_sel = '0;
  logic       free_run = 1'b0, tx_en = 1'b0;
  logic       line5 = 1'b0, click = 1'b0, rx_sync = 1'b0, sw_sync = 1'b0;
  logic       half_tick, frame_start, frame_active;
  logic [6:0] bit_idx;

  int cyc = 0;
  int n_vec = 0, n_bad = 0;
  int exp_q[$];
  bit rx_run = 1'b0;
  int rx_ph = 0;
  bit done = 1'b0;

  localparam int FRAME = 640; // divider 3: 160 * 4

  ltc_tx_timing u_ltc_tx_timing (
    .clk_i(clk), .rst_ni(rst_ni),
    .div_lo_we_i(div_lo_we), .div_hi_we_i(div_hi_we), .div_wdata_i(div_wdata),
    .src_rx_i(src_rx), .rx_clk_i(rx_clk),
    .sync_sel_i(sync_sel), .free_run_i(free_run), .tx_en_i(tx_en),
    .line5_i(line5), .click_i(click), .rx_sync_i(rx_sync), .sw_sync_i(sw_sync),
    .half_tick_o(half_tick), .bit_idx_o(bit_idx),
    .frame_start_o(frame_start), .frame_active_o(frame_active)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk); #1;
    if (rx_run) begin
      if (rx_ph == 2) begin rx_clk = ~rx_clk; rx_ph = 0; end
      else rx_ph++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic expect_start(input int c); exp_q.push_back(c); endtask

  // monitor: scoreboard of frame starts
  always @(negedge clk) begin
    if (rst_ni && frame_start) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected frame start", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R7 frame start cycle", cyc, e);
      end
    end
  end

  task automatic pulse(ref logic sig, output int start);
    step(); sig = 1'b1; start = cyc + 1;
    step(); sig = 1'b0;
  endtask

  task automatic wr_div(input bit hi, input logic [7:0] d);
    step(); div_wdata = d; if (hi) div_hi_we = 1'b1; else div_lo_we = 1'b1;
    step(); div_hi_we = 1'b0; div_lo_we = 1'b0;
  endtask

  task automatic wait_until(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic next_tick(output int c);
    do @(negedge clk); while (!half_tick);
    c = cyc;
  endtask

  task automatic tick_gap(output int gap);
    int a, b;
    next_tick(a);
    next_tick(b);
    gap = b - a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int s, g, t0, t1, t2, d;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(!frame_active, "R7 reset active", frame_active, 0);
    check(bit_idx == 0, "R7 reset index", bit_idx, 0);
    check(!frame_start, "R7 reset start", frame_start, 0);

    tick_gap(g);
    check(g == 1, "R2 divider 0 tick gap", g, 1);

    // R1: upper nibble of high write ignored
    wr_div(1'b0, 8'h03);
    wr_div(1'b1, 8'hF0);
    tick_gap(g); tick_gap(g);
    check(g == 4, "R1 R2 divider 3 tick gap", g, 4);

    // R4: write applies at next reload only
    next_tick(t0);
    step(); div_wdata = 8'h07; div_lo_we = 1'b1;
    step(); div_lo_we = 1'b0;
    next_tick(t1);
    check(t1 - t0 == 4, "R4 running half-bit keeps old length", t1 - t0, 4);
    next_tick(t2);
    check(t2 - t1 == 8, "R4 new divider after reload", t2 - t1, 8);
    wr_div(1'b0, 8'h03);
    tick_gap(g); tick_gap(g);
    check(g == 4, "R4 divider restored", g, 4);

    // R6 R7 R5 R9 R11: line-5 source, single frame
    sync_sel = 2'd0; free_run = 1'b0; tx_en = 1'b1;
    pulse(line5, s); expect_start(s);
    wait_until(s);
    check(frame_active && bit_idx == 0, "R7 start state", bit_idx, 0);
    next_tick(t0);
    check(t0 == s + 3, "R7 divider restart at frame start", t0, s + 3);
    wait_until(s + 80);
    check(bit_idx == 10, "R5 bit index advance", bit_idx, 10);
    wait_until(s + 99);
    pulse(line5, d); // R11: ignored while active
    wait_until(s + FRAME - 1);
    check(frame_active && bit_idx == 79, "R5 last bit", bit_idx, 79);
    wait_until(s + FRAME);
    check(!frame_active, "R9 frame ends after bit 79", frame_active, 0);
    wait_until(s + FRAME + 30);
    check(!frame_active, "R9 no restart without sync", frame_active, 0);

    // R6: unselected sources ignored
    sync_sel = 2'd2;
    pulse(line5, d); pulse(sw_sync, d);
    wait_until(cyc + 5);
    check(!frame_active, "R6 unselected event ignored", frame_active, 0);
    pulse(rx_sync, s); expect_start(s);
    wait_until(s + 2);
    check(frame_active, "R6 rx sync starts frame", frame_active, 1);
    wait_until(s + FRAME + 5);

    // R12: click edge only
    sync_sel = 2'd1;
    step(); click = 1'b1; s = cyc + 1; expect_start(s);
    wait_until(s + FRAME + 40);
    check(!frame_active, "R12 held click gives one event", frame_active, 0);
    step(); click = 1'b0;
    step(); step(); click = 1'b1; s = cyc + 1; expect_start(s);
    wait_until(s + 2);
    check(frame_active, "R12 new click edge starts frame", frame_active, 1);
    wait_until(s + FRAME + 5);
    step(); click = 1'b0;

    // R8 R10: software sync, free run
    sync_sel = 2'd3; free_run = 1'b1;
    wait_until(cyc + 50);
    check(!frame_active, "R8 first frame waits for sync", frame_active, 0);
    pulse(sw_sync, s);
    expect_start(s); expect_start(s + FRAME); expect_start(s + 2 * FRAME);
    wait_until(s + FRAME);
    check(frame_active && bit_idx == 0, "R8 chained frame", bit_idx, 0);
    wait_until(s + 2 * FRAME + 99);
    step(); tx_en = 1'b0;
    wait_until(s + 3 * FRAME - 1);
    check(frame_active && bit_idx == 79, "R10 frame completes after disable", bit_idx, 79);
    wait_until(s + 3 * FRAME);
    check(!frame_active, "R10 active drops at frame end", frame_active, 0);

    // R3: receive clock source, doubled
    free_run = 1'b0;
    step(); src_rx = 1'b1; rx_run = 1'b1;
    wr_div(1'b0, 8'h01);
    tick_gap(g); tick_gap(g); tick_gap(g);
    check(g == 6, "R3 one tick per receive period", g, 6);

    wait_until(cyc + 10);
    check(exp_q.size() == 0, "R11 all expected frame starts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule